// File: doc/BRIEF.md
# Cascaded Parallel-In Serial-Out Chain Reader

This controller sits on the host side of a daisy chain of `NUM_DEV` eight-bit parallel-in, serial-out shift registers. In the chain, the last stage of each register drives the serial input of the next, so the whole chain returns its bits on a single line. A one-cycle `start` request makes the controller pull the active-low capture line low for a programmable number of system clocks. It then toggles the shift clock `8*NUM_DEV` times and collects one returned bit per shift. At the end it presents the assembled word together with a one-cycle `done` strobe.

The ordering of the control lines does most of the work. The shift clock is parked high during the whole capture pulse and while the capture line is released. A rising clock edge therefore never coincides with capture. The bit nearest the controller is already on the return line when capture ends, so every sample is taken while the shift clock is low, just before the rising edge that would replace it. The half-period of the shift clock and the capture pulse width are both counted in system clocks and set by parameters.

Top module: `piso_chain_reader`

## Requirements
- R1: While reset is applied and right after it is released, `load_n` and `sclk` are 1, `busy` and `done` are 0 and `data_out` is all zeros.
- R2: A `start` seen while idle drives `load_n` low for exactly `LOAD_CYC` system clocks, with `sclk` held at 1 throughout.
- R3: `sclk` never rises while `load_n` is 0, and `sclk` is already 1 at the moment `load_n` returns to 1.
- R4: One transaction produces exactly `8*NUM_DEV` rising edges on `sclk`, and every low phase of `sclk` lasts `HALF_DIV` system clocks.
- R5: `ser_in` is sampled in the last system clock of each `sclk` low phase, so the first sample comes before any rising edge and no sample follows the final edge. The first bit received lands in bit `8*NUM_DEV-1` of `data_out` and later bits fill lower positions in arrival order. The register nearest the controller therefore fills the top byte, with its bit 7 as the MSB.
- R6: `done` is high for exactly one system clock, and the full word is already on `data_out` in that cycle. `busy` is 1 from the cycle after `start` is accepted through the `done` cycle, and 0 in the cycle after it.
- R7: A `start` raised while `busy` is 1 has no effect: there is no extra capture pulse, no extra `sclk` edge and no second `done`.
- R8: After `done`, `load_n` and `sclk` stay at 1 and `data_out` keeps the last word until samples of a new transaction arrive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Request to read the chain; ignored while busy |
| ser_in | input | 1 | Serial return from the last stage of the nearest register |
| load_n | output | 1 | Active-low parallel capture line to all registers |
| sclk | output | 1 | Shift clock to all registers, rising edge shifts |
| busy | output | 1 | High while a read is in progress |
| done | output | 1 | One-cycle strobe, word valid |
| data_out | output | 8*NUM_DEV | Assembled word, first received bit in the MSB |

## Verification
A wrong state or timer value shows up at the pins within one shift-clock period. The result is a capture pulse of the wrong width, an `sclk` phase that is too short or too long, or a rising edge while capture is active. A bit counter that is off by one shows up only at the end of the read, as a wrong number of `sclk` edges and a word shifted by one position when `done` arrives. The bench models the chain as one register that the controller's own `load_n` and `sclk` drive. Because of this, any error in how the lines are ordered corrupts the returned word, which is compared with the pattern that was captured.

// File: rtl/piso_rd_pkg.sv
package piso_rd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_LOAD  = 3'd1,
    ST_SETUP = 3'd2,
    ST_LOW   = 3'd3,
    ST_HIGH  = 3'd4,
    ST_FIN   = 3'd5
  } rd_state_t;
endpackage

// File: rtl/piso_rd_rst_sync.sv
module piso_rd_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/piso_rd_timer.sv
// Phase timer: loaded with (length-1) on phase entry, flags zero at phase end.
module piso_rd_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld,
  input  logic [CNT_W-1:0] ld_val,
  output logic             zero
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (ld)                cnt_d = ld_val;
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/piso_rd_capture.sv
// Collects returned serial bits MSB first and counts them.
module piso_rd_capture #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              smp,
  input  logic              bit_in,
  output logic [WORD_W-1:0] word,
  output logic              full
);
  localparam int CW = $clog2(WORD_W + 1);

  logic [WORD_W-1:0] word_q, word_d;
  logic [CW-1:0]     cnt_q, cnt_d;

  always_comb begin
    word_d = word_q;
    cnt_d  = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (smp) begin
      word_d = {word_q[WORD_W-2:0], bit_in};
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      cnt_q  <= '0;
    end else begin
      word_q <= word_d;
      cnt_q  <= cnt_d;
    end
  end

  assign word = word_q;
  assign full = (cnt_q == CW'(WORD_W));

  // R5
  // no sample may be requested once the word is complete
  no_oversample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp |-> !full);
endmodule

// File: rtl/piso_chain_reader.sv
module piso_chain_reader
  import piso_rd_pkg::*;
#(
  parameter int NUM_DEV  = 2,
  parameter int HALF_DIV = 2,
  parameter int LOAD_CYC = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic                   ser_in,
  output logic                   load_n,
  output logic                   sclk,
  output logic                   busy,
  output logic                   done,
  output logic [8*NUM_DEV-1:0]   data_out
);
  localparam int WORD_W = 8 * NUM_DEV;
  localparam int MAXC   = (LOAD_CYC > HALF_DIV) ? LOAD_CYC : HALF_DIV;
  localparam int TW     = $clog2(MAXC + 1);
  localparam logic [TW-1:0] LOAD_V = TW'(LOAD_CYC - 1);
  localparam logic [TW-1:0] HALF_V = TW'(HALF_DIV - 1);

  logic          rst_n_s;
  rd_state_t     st_q, st_d;
  logic          tmr_ld, tmr_zero;
  logic [TW-1:0] tmr_val;
  logic          cap_clr, cap_smp, cap_full;

  piso_rd_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  piso_rd_timer #(.CNT_W(TW)) u_tmr (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .ld     (tmr_ld),
    .ld_val (tmr_val),
    .zero   (tmr_zero)
  );

  piso_rd_capture #(.WORD_W(WORD_W)) u_cap (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .clr    (cap_clr),
    .smp    (cap_smp),
    .bit_in (ser_in),
    .word   (data_out),
    .full   (cap_full)
  );

  // next-state logic
  always_comb begin
    st_d    = st_q;
    tmr_ld  = 1'b0;
    tmr_val = '0;
    cap_clr = 1'b0;
    cap_smp = 1'b0;
    unique case (st_q)
      ST_IDLE: if (start) begin
        st_d    = ST_LOAD;
        tmr_ld  = 1'b1;
        tmr_val = LOAD_V;
        cap_clr = 1'b1;
      end
      ST_LOAD: if (tmr_zero) begin
        st_d    = ST_SETUP;
        tmr_ld  = 1'b1;
        tmr_val = HALF_V;
      end
      ST_SETUP: if (tmr_zero) begin
        st_d    = ST_LOW;
        tmr_ld  = 1'b1;
        tmr_val = HALF_V;
      end
      ST_LOW: if (tmr_zero) begin
        cap_smp = 1'b1;          // sample just before the rising edge
        st_d    = ST_HIGH;
        tmr_ld  = 1'b1;
        tmr_val = HALF_V;
      end
      ST_HIGH: if (tmr_zero) begin
        if (cap_full) begin
          st_d = ST_FIN;
        end else begin
          st_d    = ST_LOW;
          tmr_ld  = 1'b1;
          tmr_val = HALF_V;
        end
      end
      ST_FIN:  st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  // state and registered pin drivers
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      st_q   <= ST_IDLE;
      load_n <= 1'b1;
      sclk   <= 1'b1;
      busy   <= 1'b0;
      done   <= 1'b0;
    end else begin
      st_q   <= st_d;
      load_n <= (st_d != ST_LOAD);
      sclk   <= (st_d != ST_LOW);
      busy   <= (st_d != ST_IDLE);
      done   <= (st_d == ST_FIN);
    end
  end

  // R3
  no_shift_in_load_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    !load_n |-> sclk);

  // R3
  clk_high_at_release_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(load_n) |-> sclk);

  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    done |=> !done);

  // R6
  done_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    done |-> busy);

  // R7
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (busy && !done) |=> busy);

  // R8
  idle_lines_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    !busy |-> (load_n && sclk));
endmodule

// File: tb/piso_chain_reader_test.sv
module piso_chain_reader_test;
  localparam int CLK_PERIOD = 10;
  localparam int NDEV = 3;
  localparam int HD   = 2;
  localparam int LC   = 3;
  localparam int WW   = 8 * NDEV;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic ser_in;
  logic load_n, sclk, busy, done;
  logic [WW-1:0] data_out;

  logic [WW-1:0] par_word = '0;
  logic [WW-1:0] chain = '0;
  logic          tail = 1'b0;

  int total = 0;
  int bad = 0;
  int rises = 0, shift_in_load = 0, release_bad = 0;
  int low_run = 0, low_bad = 0, load_run = 0, last_load_w = 0;
  int done_cnt = 0;
  int wd = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  piso_chain_reader #(.NUM_DEV(NDEV), .HALF_DIV(HD), .LOAD_CYC(LC)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .ser_in(ser_in),
    .load_n(load_n), .sclk(sclk), .busy(busy), .done(done), .data_out(data_out)
  );

  // chain model: nearest register occupies the top byte
  always @(posedge sclk or negedge load_n) begin
    if (!load_n) chain <= par_word;
    else         chain <= {chain[WW-2:0], tail};
  end
  assign ser_in = chain[WW-1];

  always @(posedge sclk) begin
    rises++;
    if (load_n !== 1'b1) shift_in_load++;
  end

  always @(posedge load_n) if (sclk !== 1'b1) release_bad++;

  always @(negedge clk) begin
    if (sclk === 1'b0) low_run++;
    else begin
      if (low_run != 0 && low_run != HD) low_bad++;
      low_run = 0;
    end
    if (load_n === 1'b0) load_run++;
    else begin
      if (load_run != 0) last_load_w = load_run;
      load_run = 0;
    end
    if (done === 1'b1) done_cnt++;
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=%0d expected<=150000", wd);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [WW-1:0] expect_word(input logic [WW-1:0] captured);
    return captured;   // first bit out is MSB of the nearest register
  endfunction

  task automatic run_txn(input logic [WW-1:0] word, input bit restart_mid);
    int cyc;
    par_word = word;
    tail = 1'($urandom);
    rises = 0; shift_in_load = 0; release_bad = 0;
    low_bad = 0; last_load_w = 0; done_cnt = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk(busy === 1'b1, "R6", "busy after start", longint'(busy), 1);
    chk(load_n === 1'b0 && sclk === 1'b1, "R2", "load low with sclk high",
        longint'({load_n, sclk}), 1);
    cyc = 0;
    while (done !== 1'b1 && cyc < 2000) begin
      @(negedge clk);
      cyc++;
      start = (restart_mid && cyc == 20);
    end
    start = 1'b0;
    chk(cyc < 2000, "R6", "done arrives", cyc, 0);
    chk(data_out === expect_word(word), "R5", "word", longint'(data_out),
        longint'(expect_word(word)));
    chk(busy === 1'b1, "R6", "busy at done", longint'(busy), 1);
    chk(rises == WW, "R4", "sclk edges", rises, WW);
    chk(low_bad == 0, "R4", "low phase width errors", low_bad, 0);
    chk(shift_in_load == 0 && release_bad == 0, "R3", "edge during load",
        shift_in_load + release_bad, 0);
    chk(last_load_w == LC, "R2", "load width", last_load_w, LC);
    @(negedge clk);
    chk(done === 1'b0 && busy === 1'b0, "R6", "done one cycle, busy drops",
        longint'({done, busy}), 0);
    chk(load_n === 1'b1 && sclk === 1'b1, "R8", "idle lines", longint'({load_n, sclk}), 3);
    repeat (6) @(negedge clk);
    chk(rises == WW && done_cnt == 1, "R7", "no extra activity",
        rises * 16 + done_cnt, WW * 16 + 1);
    chk(data_out === word, "R8", "word held", longint'(data_out), longint'(word));
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk(load_n === 1'b1 && sclk === 1'b1, "R1", "lines in reset", longint'({load_n, sclk}), 3);
    chk(busy === 1'b0 && done === 1'b0, "R1", "flags in reset", longint'({busy, done}), 0);
    chk(data_out === '0, "R1", "word in reset", longint'(data_out), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(load_n === 1'b1 && sclk === 1'b1 && busy === 1'b0 && done === 1'b0,
        "R1", "after release", longint'({load_n, sclk, busy, done}), 12);

    run_txn('0, 1'b0);
    run_txn('1, 1'b0);
    run_txn(24'hA55A3C, 1'b0);
    run_txn(24'h800000, 1'b0);
    run_txn(24'h000001, 1'b0);
    run_txn(24'h5AC381, 1'b1);   // R7 start while busy
    for (int i = 0; i < 8; i++) run_txn(WW'($urandom), (i % 3) == 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule